// File: doc/BRIEF.md
# Subranging converter correction decoder

This block is the digital back end of an 8-bit subranging analog-to-digital converter. The front end makes three comparator passes per conversion. A six-comparator coarse estimator runs first. Eight shared comparators then run twice: once against a coarse ladder window and once against a fine subdivision of one coarse tap. The block receives each pass on a strobe of its own. It turns the thermometer codes into counts and repairs the coarse estimate with the first flash pass. It then builds the 5-bit coarse tap, appends the fine bits and registers an 8-bit result with an overflow flag.

The coarse window is twice as wide as one estimator step, so each window overlaps the neighbouring estimator region by half a step on each side. An estimator that is off by up to that overlap still leads to a correct tap. The corrected 2-bit estimate is the upper part of that tap. The block reports the window index after the estimator pass and the coarse tap after the first flash pass, so that a ladder model can place the comparator thresholds for the next pass. Bubbles in a thermometer code are tolerated by counting ones. Each bubble raises an error flag that lasts until the next conversion starts.

Top module: `adcdec_top`

## Requirements
- R1: On an `est_valid_i` edge the estimator code (bit 0 is the lowest comparator) is reduced to its count of ones n (0..6). `win_o` becomes n and `est_o` becomes min(3, (n+1)>>1), so 6'b000111 gives `est_o`=2'b10 and `win_o`=3.
- R2: On an accepted `flash1_valid_i` edge, `tap_o` becomes 4*`win_o` + (ones in `cmp_i`), range 0..32. `corr_o` becomes min(3, `tap_o`>>3). For an odd window this is `est_o`-1 when fewer than 4 comparators are set and `est_o` otherwise. `corr_o` never differs from `est_o` by two.
- R3: On an accepted `flash2_valid_i` edge the sum 8*`tap_o` + (ones in `cmp_i`) is formed. If it exceeds 255, `ovf_o` is 1 and `result_o` is 8'hFF. Otherwise `ovf_o` is 0 and `result_o` is the sum.
- R4: `done_o` is high for exactly one cycle, the cycle after the edge that accepts `flash2_valid_i`. `result_o` and `ovf_o` hold their values until the next accepted second pass.
- R5: A `flash1_valid_i` with no estimator pass pending is ignored. A `flash2_valid_i` with no first flash pending is ignored. Neither changes `tap_o`, `result_o` or `done_o`.
- R6: An `est_valid_i` in any phase restarts the conversion and takes priority over flash strobes in the same cycle. `tap_o` and `corr_o` are cleared to 0.
- R7: A non-monotonic code (a set bit above a clear bit) is decoded by counting ones and sets `err_o`. `err_o` stays set through the `done_o` cycle and is cleared by the next `est_valid_i`.
- R8: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| est_valid_i | input | 1 | Estimator pass strobe |
| est_code_i | input | 6 | Estimator thermometer code |
| flash1_valid_i | input | 1 | First flash pass strobe |
| flash2_valid_i | input | 1 | Second flash pass strobe |
| cmp_i | input | 8 | Shared flash comparator code |
| est_o | output | 2 | Raw 2-bit coarse estimate |
| win_o | output | 3 | Coarse window index for the first pass |
| corr_o | output | 2 | Corrected 2-bit estimate |
| tap_o | output | 6 | Coarse tap, window for the second pass |
| done_o | output | 1 | One-cycle conversion complete pulse |
| result_o | output | 8 | Converted value |
| ovf_o | output | 1 | Result above full scale |
| err_o | output | 1 | Bubble seen in this conversion |

## Verification
The vector table covers centred windows with a first pass below and above the midpoint, which separates the decrement from the unchanged estimate. Edge-anchored windows show the estimate moving upward. The bottom code, top coarse taps with and without a fine carry past 255, and a result of exactly 255 separate overflow from saturation. Bubbled codes in each of the three passes, each followed by a clean conversion, show the error flag both set and cleared. Directed cases send strobes out of order, restart mid-conversion and assert reset mid-conversion; they check that stale state never leaks into a result.

// File: rtl/adcdec_pkg.sv
package adcdec_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EST  = 2'd1,
        PH_F1   = 2'd2
    } phase_e;

endpackage

// File: rtl/adcdec_therm.sv
// Thermometer code to ones count, with bubble detection.
module adcdec_therm #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [W-1:0]  code_i,
    output logic [CW-1:0] ones_o,
    output logic          bubble_o
);

    logic [W-1:0] below;

    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CW'(code_i[i]);
        end
    end

    // bit i may only be set if bit i-1 is set; bit -1 counts as set
    assign below    = {code_i[W-2:0], 1'b1};
    assign bubble_o = |(code_i & ~below);

endmodule

// File: rtl/adcdec_coarse.sv
// Coarse tap from window index and first flash count; corrected estimate.
module adcdec_coarse #(
    parameter int WIN_W = 3,
    parameter int FL_CW = 4,
    parameter int TAP_W = 6,
    parameter int HALF  = 4,
    parameter int LSB_W = 3
) (
    input  logic [WIN_W-1:0] win_i,
    input  logic [FL_CW-1:0] ones_i,
    output logic [TAP_W-1:0] tap_o,
    output logic [1:0]       corr_o
);

    logic [TAP_W-1:0] hi;

    always_comb begin
        tap_o  = TAP_W'(win_i) * TAP_W'(HALF) + TAP_W'(ones_i);
        hi     = tap_o >> LSB_W;
        corr_o = (hi > TAP_W'(3)) ? 2'd3 : hi[1:0];
    end

endmodule

// File: rtl/adcdec_fine.sv
// Appends the fine count to the coarse tap and saturates.
module adcdec_fine #(
    parameter int TAP_W = 6,
    parameter int FL_CW = 4,
    parameter int FL_W  = 8,
    parameter int RES_W = 8,
    parameter int SUM_W = 9
) (
    input  logic [TAP_W-1:0] tap_i,
    input  logic [FL_CW-1:0] ones_i,
    output logic [RES_W-1:0] result_o,
    output logic             ovf_o
);

    localparam logic [SUM_W-1:0] FULL = SUM_W'((1 << RES_W) - 1);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum      = SUM_W'(tap_i) * SUM_W'(FL_W) + SUM_W'(ones_i);
        ovf_o    = sum > FULL;
        result_o = ovf_o ? '1 : sum[RES_W-1:0];
    end

endmodule

// File: rtl/adcdec_top.sv
module adcdec_top
    import adcdec_pkg::*;
#(
    parameter int EST_W = 6,
    parameter int FL_W  = 8,
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             est_valid_i,
    input  logic [EST_W-1:0] est_code_i,
    input  logic             flash1_valid_i,
    input  logic             flash2_valid_i,
    input  logic [FL_W-1:0]  cmp_i,
    output logic [1:0]       est_o,
    output logic [2:0]       win_o,
    output logic [1:0]       corr_o,
    output logic [5:0]       tap_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o,
    output logic             ovf_o,
    output logic             err_o
);

    localparam int EST_CW = $clog2(EST_W + 1);
    localparam int FL_CW  = $clog2(FL_W + 1);
    localparam int HALF   = FL_W / 2;
    localparam int LSB_W  = $clog2(FL_W);
    localparam int TAP_MX = HALF * EST_W + FL_W;
    localparam int TAP_W  = $clog2(TAP_MX + 1);
    localparam int SUM_W  = $clog2(FL_W * TAP_MX + FL_W + 1);

    typedef struct packed {
        phase_e             phase;
        logic [1:0]         est;
        logic [EST_CW-1:0]  win;
        logic [1:0]         corr;
        logic [TAP_W-1:0]   tap;
        logic               done;
        logic [RES_W-1:0]   result;
        logic               ovf;
        logic               err;
    } state_t;

    state_t st_d, st_q;

    logic [EST_CW-1:0] est_ones;
    logic              est_bub;
    logic [FL_CW-1:0]  cmp_ones;
    logic              cmp_bub;
    logic [TAP_W-1:0]  tap_w;
    logic [1:0]        corr_w;
    logic [RES_W-1:0]  res_w;
    logic              ovf_w;
    logic [EST_CW:0]   est_half;

    adcdec_therm #(.W(EST_W), .CW(EST_CW)) u_est_therm (
        .code_i   (est_code_i),
        .ones_o   (est_ones),
        .bubble_o (est_bub)
    );

    adcdec_therm #(.W(FL_W), .CW(FL_CW)) u_cmp_therm (
        .code_i   (cmp_i),
        .ones_o   (cmp_ones),
        .bubble_o (cmp_bub)
    );

    adcdec_coarse #(
        .WIN_W (EST_CW), .FL_CW (FL_CW), .TAP_W (TAP_W),
        .HALF  (HALF),   .LSB_W (LSB_W)
    ) u_coarse (
        .win_i  (st_q.win),
        .ones_i (cmp_ones),
        .tap_o  (tap_w),
        .corr_o (corr_w)
    );

    adcdec_fine #(
        .TAP_W (TAP_W), .FL_CW (FL_CW), .FL_W (FL_W),
        .RES_W (RES_W), .SUM_W (SUM_W)
    ) u_fine (
        .tap_i    (st_q.tap),
        .ones_i   (cmp_ones),
        .result_o (res_w),
        .ovf_o    (ovf_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        est_half  = ({1'b0, est_ones} + (EST_CW + 1)'(1)) >> 1;
        if (est_valid_i) begin
            st_d.phase = PH_EST;
            st_d.win   = est_ones;
            st_d.est   = (est_half > (EST_CW + 1)'(3)) ? 2'd3 : est_half[1:0];
            st_d.corr  = '0;
            st_d.tap   = '0;
            st_d.err   = est_bub;
        end else if (flash1_valid_i && st_q.phase == PH_EST) begin
            st_d.phase = PH_F1;
            st_d.tap   = tap_w;
            st_d.corr  = corr_w;
            st_d.err   = st_q.err | cmp_bub;
        end else if (flash2_valid_i && st_q.phase == PH_F1) begin
            st_d.phase  = PH_IDLE;
            st_d.done   = 1'b1;
            st_d.result = res_w;
            st_d.ovf    = ovf_w;
            st_d.err    = st_q.err | cmp_bub;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign est_o    = st_q.est;
    assign win_o    = 3'(st_q.win);
    assign corr_o   = st_q.corr;
    assign tap_o    = 6'(st_q.tap);
    assign done_o   = st_q.done;
    assign result_o = st_q.result;
    assign ovf_o    = st_q.ovf;
    assign err_o    = st_q.err;

    // R1: a clean estimator code equals the mask of its own count
    p_therm_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (est_valid_i && !est_bub) |->
        ({1'b0, est_code_i} == (((EST_CW + 1 + EST_W)'(1) << est_ones) - 1'b1) >> 0
            ? 1'b1 : 1'b0) == 1'b1);

    // R2: corrected estimate is within one step of the raw estimate
    p_corr_near_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_F1) |-> ((st_q.corr - st_q.est) != 2'd2));

    // R3: an overflowing result is saturated
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (result_o == '1));

    // R4: done is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: a second-pass strobe while idle produces no done
    p_ignore_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !est_valid_i) |=> !done_o);

    // R7: error flag holds until the next estimator strobe
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !est_valid_i) |=> err_o);

endmodule

// File: tb/adcdec_top_bench.sv
module adcdec_top_bench;

    typedef struct packed {
        logic [5:0] est;
        logic [7:0] f1;
        logic [7:0] f2;
        logic [7:0] res;
        logic       ovf;
        logic       err;
        logic [1:0] e;
        logic [2:0] win;
        logic [1:0] corr;
        logic [5:0] tap;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{6'b000111, 8'h03, 8'h1F, 8'h75, 1'b0, 1'b0, 2'd2, 3'd3, 2'd1, 6'd14},
        '{6'b000111, 8'h3F, 8'h00, 8'h90, 1'b0, 1'b0, 2'd2, 3'd3, 2'd2, 6'd18},
        '{6'b000000, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 6'd0},
        '{6'b111111, 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b0, 2'd3, 3'd6, 2'd3, 6'd32},
        '{6'b111111, 8'h7F, 8'hFF, 8'hFF, 1'b1, 1'b0, 2'd3, 3'd6, 2'd3, 6'd31},
        '{6'b111111, 8'h7F, 8'h7F, 8'hFF, 1'b0, 1'b0, 2'd3, 3'd6, 2'd3, 6'd31},
        '{6'b000001, 8'h0F, 8'h07, 8'h43, 1'b0, 1'b0, 2'd1, 3'd1, 2'd1, 6'd8},
        '{6'b000011, 8'hFF, 8'h00, 8'h80, 1'b0, 1'b0, 2'd1, 3'd2, 2'd2, 6'd16},
        '{6'b011111, 8'h01, 8'h03, 8'hAA, 1'b0, 1'b0, 2'd3, 3'd5, 2'd2, 6'd21},
        '{6'b000101, 8'h0F, 8'h00, 8'h60, 1'b0, 1'b1, 2'd1, 3'd2, 2'd1, 6'd12},
        '{6'b000111, 8'h0F, 8'h81, 8'h82, 1'b0, 1'b1, 2'd2, 3'd3, 2'd2, 6'd16},
        '{6'b000111, 8'h0F, 8'h00, 8'h80, 1'b0, 1'b0, 2'd2, 3'd3, 2'd2, 6'd16},
        '{6'b000111, 8'h06, 8'h00, 8'h70, 1'b0, 1'b1, 2'd2, 3'd3, 2'd1, 6'd14}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       est_valid_i = 1'b0;
    logic [5:0] est_code_i = '0;
    logic       flash1_valid_i = 1'b0;
    logic       flash2_valid_i = 1'b0;
    logic [7:0] cmp_i = '0;
    logic [1:0] est_o;
    logic [2:0] win_o;
    logic [1:0] corr_o;
    logic [5:0] tap_o;
    logic       done_o;
    logic [7:0] result_o;
    logic       ovf_o;
    logic       err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    adcdec_top u_adcdec_top (
        .clk (clk), .rst_n (rst_n),
        .est_valid_i (est_valid_i), .est_code_i (est_code_i),
        .flash1_valid_i (flash1_valid_i), .flash2_valid_i (flash2_valid_i),
        .cmp_i (cmp_i),
        .est_o (est_o), .win_o (win_o), .corr_o (corr_o), .tap_o (tap_o),
        .done_o (done_o), .result_o (result_o), .ovf_o (ovf_o), .err_o (err_o)
    );

    always #(2.5ns) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        est_valid_i = 1'b1; est_code_i = v.est;
        @(negedge clk);
        est_valid_i = 1'b0;
        chk($sformatf("R1 est_o vec %0d", idx), 32'(est_o), 32'(v.e));
        chk($sformatf("R1 win_o vec %0d", idx), 32'(win_o), 32'(v.win));
        flash1_valid_i = 1'b1; cmp_i = v.f1;
        @(negedge clk);
        flash1_valid_i = 1'b0;
        chk($sformatf("R2 corr_o vec %0d", idx), 32'(corr_o), 32'(v.corr));
        chk($sformatf("R2 tap_o vec %0d", idx), 32'(tap_o), 32'(v.tap));
        flash2_valid_i = 1'b1; cmp_i = v.f2;
        @(negedge clk);
        flash2_valid_i = 1'b0; cmp_i = '0;
        chk($sformatf("R4 done vec %0d", idx), 32'(done_o), 32'd1);
        chk($sformatf("R3 result vec %0d", idx), 32'(result_o), 32'(v.res));
        chk($sformatf("R3 ovf vec %0d", idx), 32'(ovf_o), 32'(v.ovf));
        chk($sformatf("R7 err vec %0d", idx), 32'(err_o), 32'(v.err));
        @(negedge clk);
        chk($sformatf("R4 done drop vec %0d", idx), 32'(done_o), 32'd0);
        chk($sformatf("R4 result hold vec %0d", idx), 32'(result_o), 32'(v.res));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 outputs during reset
        chk("R8 done", 32'(done_o), 32'd0);
        chk("R8 result", 32'(result_o), 32'd0);
        chk("R8 est/win/corr/tap", {est_o, win_o, corr_o, tap_o, ovf_o, err_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: flash strobes with no estimator pass
        flash1_valid_i = 1'b1; cmp_i = 8'hFF;
        @(negedge clk);
        flash1_valid_i = 1'b0; flash2_valid_i = 1'b1;
        chk("R5 tap after stray flash1", 32'(tap_o), 32'd0);
        @(negedge clk);
        flash2_valid_i = 1'b0;
        chk("R5 no done after stray flash2", 32'(done_o), 32'd0);
        // R5: estimator then flash2 without flash1
        est_valid_i = 1'b1; est_code_i = 6'b000111;
        @(negedge clk);
        est_valid_i = 1'b0; flash2_valid_i = 1'b1; cmp_i = 8'hFF;
        @(negedge clk);
        flash2_valid_i = 1'b0; cmp_i = '0;
        chk("R5 no done skipped flash1", 32'(done_o), 32'd0);
        chk("R5 result untouched", 32'(result_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end

        // R6: restart in the middle of a conversion
        @(negedge clk);
        est_valid_i = 1'b1; est_code_i = 6'b111111;
        @(negedge clk);
        est_code_i = 6'b000001;
        flash1_valid_i = 1'b1; cmp_i = 8'hFF;
        @(negedge clk);
        est_valid_i = 1'b0; flash1_valid_i = 1'b0;
        chk("R6 restart est_o", 32'(est_o), 32'd1);
        chk("R6 restart tap cleared", 32'(tap_o), 32'd0);
        flash1_valid_i = 1'b1; cmp_i = 8'h0F;
        @(negedge clk);
        flash1_valid_i = 1'b0; flash2_valid_i = 1'b1; cmp_i = 8'h07;
        @(negedge clk);
        flash2_valid_i = 1'b0;
        chk("R6 restart result", 32'(result_o), 32'h43);

        // R8: reset mid-conversion
        est_valid_i = 1'b1; est_code_i = 6'b000101;
        @(negedge clk);
        est_valid_i = 1'b0; flash1_valid_i = 1'b1; cmp_i = 8'hFF;
        @(negedge clk);
        flash1_valid_i = 1'b0;
        rst_n = 1'b0;
        #1ns;
        chk("R8 mid reset outputs",
            {result_o, est_o, win_o, corr_o, tap_o, done_o, ovf_o, err_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule